// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Requester

This block is the processor-side master of a system bus on which one set of lines carries both addresses and data. A separate 9-bit command bus travels with every cycle and has its own parity bit. Requests come in through a valid/ready port and wait in a small in-order queue. There are four kinds: single-word read, single-word write, four-word block read and four-word block write. The block runs one bus transaction at a time. Each transaction starts with an address cycle. For a read, the block then hands the bus to the external agent. For a write, it sends the data itself.

A bus width is chosen in the first clock after reset. Wide mode moves a 64-bit word per beat. Narrow mode moves 32-bit beats and sends each 64-bit word as two beats. A 4-bit pacing mask, also captured at that time, sets how fast write data goes out. Read data is accepted whenever the agent strobes input-valid on a data-tagged cycle. Each returned word is presented on a response port with a last flag. Check bits on returned data and command are verified, and any mismatch raises a sticky error flag.

Top module: `sbr_requester`

## Requirements
- R1: While reset is asserted and right after it, `bus_vout`, `bus_release`, `bus_ad_oe`, `rsp_valid` and `par_err` are low, and `req_ready` is high after reset.
- R2: An address cycle drives `bus_vout`=1 and `bus_ad_oe`=1. The address appears on `bus_ad_o[31:0]` with the upper bits zero. `bus_cmd_o[8]`=0 and `bus_cmd_o[7:5]` is the type: 000 single read, 001 block read, 010 single write, 011 block write. The other command bits are zero. On every driven cycle, `bus_cmdp_o` equals the XOR of all nine command bits.
- R3: A read address cycle only follows a cycle in which `bus_rd_rdy` was high. A write address cycle only follows a cycle in which `bus_wr_rdy` was high.
- R4: The cycle after a read address cycle has `bus_release`=1 and `bus_ad_oe`=0. The requester does not drive the bus again until the read completes.
- R5: A write data cycle has `bus_cmd_o[8]`=1, and `bus_cmd_o[5]` is set only on the final beat. On every driven cycle, `bus_chk_o[k]` is the XOR of `bus_ad_o[8k+7:8k]`.
- R6: The pacing mask `cfg_pace` is captured at the first clock after reset. Cycle i after the write address cycle, counted from 0 and taken modulo 4, carries data exactly when mask bit i is set. A mask of 0 means every cycle carries data.
- R7: In narrow mode (`cfg_narrow`=1), each 64-bit word goes out as two beats on `bus_ad_o[31:0]`, low half first, with `bus_ad_o[63:32]` and `bus_chk_o[7:4]` zero. Returned words are assembled the same way, low half first.
- R8: A returned beat is taken only in a cycle with `bus_vin`=1 and `bus_cmd_i[8]`=1. `rsp_valid` pulses one cycle after each completed word, carrying the word on `rsp_data`. `rsp_last` is high on the final word of the transaction.
- R9: A returned beat whose check bits do not match its data is a parity error. Only lanes 3:0 are checked in narrow mode. A beat whose `bus_cmdp_i` does not match the XOR of `bus_cmd_i` is also a parity error. Any such error sets `par_err`, which stays set until reset, and the transfer continues.
- R10: The queue holds up to `QDEPTH` (default 2) requests while the bus is busy. `req_ready` is low when it is full, and requests are served in arrival order.
- R11: Only one transaction is outstanding. No address cycle appears until the previous transaction's final beat has passed, and the cycle after a final write beat has `bus_vout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_narrow | input | 1 | 1 selects 32-bit beats, captured after reset |
| cfg_pace | input | 4 | Write data pacing mask, captured after reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue can accept a request |
| req_kind | input | 2 | 00 read, 01 write, 10 block read, 11 block write |
| req_addr | input | 32 | Transaction address |
| req_wdata | input | 256 | Four write words, word 0 in bits 63:0 |
| rsp_valid | output | 1 | Returned word valid |
| rsp_data | output | 64 | Returned word |
| rsp_last | output | 1 | Final word of the read |
| par_err | output | 1 | Sticky returned-parity error |
| bus_ad_o | output | 64 | Address/data driven value |
| bus_ad_i | input | 64 | Address/data received value |
| bus_ad_oe | output | 1 | Requester drives address/data lines |
| bus_chk_o | output | 8 | Driven check bits |
| bus_chk_i | input | 8 | Received check bits |
| bus_cmd_o | output | 9 | Driven command |
| bus_cmd_i | input | 9 | Received command |
| bus_cmdp_o | output | 1 | Driven command parity |
| bus_cmdp_i | input | 1 | Received command parity |
| bus_vout | output | 1 | Requester output-valid strobe |
| bus_vin | input | 1 | Agent input-valid strobe |
| bus_rd_rdy | input | 1 | Agent can take a read request |
| bus_wr_rdy | input | 1 | Agent can take a write request |
| bus_release | output | 1 | Bus handed to the agent |

## Verification
The hardest state to reach from the ports is a full queue with two different requests stacked up while no address cycle has issued. The bench gets there by holding the read-ready input low while it pushes a single read and then a block read. It then confirms that `req_ready` drops and that both are served in order once ready rises. A second hard case is a returned cycle that has input-valid high but the data tag clear, placed between real beats. The bench shows it is ignored by checking that no response pulse follows and that the next word is still assembled correctly. Narrow-mode reads put garbage on the unused upper lanes to show those lanes are left out of the parity check.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int WORD_W    = 64;
  localparam int ADDR_W    = 32;
  localparam int BLK_WORDS = 4;
  localparam int CMD_W     = 9;
  localparam int LANES     = WORD_W / 8;
  localparam int BEAT_W    = $clog2(2 * BLK_WORDS) + 1;

  typedef enum logic [1:0] {
    K_RD  = 2'b00,
    K_WR  = 2'b01,
    K_BRD = 2'b10,
    K_BWR = 2'b11
  } kind_e;

  typedef struct packed {
    kind_e                       kind;
    logic [ADDR_W-1:0]           addr;
    logic [BLK_WORDS*WORD_W-1:0] data;
  } req_t;

  function automatic logic [2:0] type_code(kind_e k);
    case (k)
      K_RD:    return 3'b000;
      K_BRD:   return 3'b001;
      K_WR:    return 3'b010;
      default: return 3'b011;
    endcase
  endfunction

  function automatic logic is_read(kind_e k);
    return ~k[0];
  endfunction

  function automatic logic is_block(kind_e k);
    return k[1];
  endfunction
endpackage

// File: rtl/sbr_parity_gen.sv
module sbr_parity_gen #(
  parameter int NLANES = 8
) (
  input  logic [NLANES*8-1:0] data,
  output logic [NLANES-1:0]   par
);
  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    assign par[k] = ^data[k*8 +: 8];
  end
endmodule

// File: rtl/sbr_req_queue.sv
module sbr_req_queue
  import sbr_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  req_t push_req,
  output logic can_push,
  input  logic pop,
  output logic head_valid,
  output req_t head
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  req_t             mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = push ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop  ? bump(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= push_req;
  end

  assign can_push   = (cnt_q != CNT_W'(DEPTH));
  assign head_valid = (cnt_q != '0);
  assign head       = mem[rd_ptr_q];

  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  p_pop_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_valid);
endmodule

// File: rtl/sbr_ctrl.sv
module sbr_ctrl
  import sbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_narrow,
  input  logic [3:0]        cfg_pace,
  input  logic              q_valid,
  input  req_t              q_head,
  output logic              q_pop,
  input  logic              rd_rdy,
  input  logic              wr_rdy,
  input  logic              vin,
  input  logic              cmd_i_data,
  output logic [WORD_W-1:0] ad_o,
  output logic              ad_oe,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              cmdp_o,
  output logic              vout,
  output logic              release_o,
  output logic              cap,
  output logic              cap_half,
  output logic              cap_last,
  output logic              narrow_o
);
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_REL, S_RDAT, S_WDAT
  } state_e;

  state_e            state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [1:0]        slot_q, slot_d;
  logic              cfg_done_q, narrow_q;
  logic [3:0]        pace_q;

  logic              rd_kind, blk_kind, last_beat, issue_ok, half;
  logic [BEAT_W-1:0] nbeats, words;
  logic [1:0]        word_idx;
  logic [3:0]        pace_eff;
  logic [WORD_W-1:0] cur_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_done_q <= 1'b0;
      narrow_q   <= 1'b0;
      pace_q     <= '0;
    end else if (!cfg_done_q) begin
      cfg_done_q <= 1'b1;
      narrow_q   <= cfg_narrow;
      pace_q     <= cfg_pace;
    end
  end

  always_comb begin
    rd_kind   = is_read(q_head.kind);
    blk_kind  = is_block(q_head.kind);
    words     = blk_kind ? BEAT_W'(BLK_WORDS) : BEAT_W'(1);
    nbeats    = narrow_q ? (words << 1) : words;
    last_beat = (beat_q == nbeats - 1'b1);
    issue_ok  = cfg_done_q && q_valid && (rd_kind ? rd_rdy : wr_rdy);
    pace_eff  = (pace_q == '0) ? 4'hF : pace_q;
    word_idx  = narrow_q ? beat_q[2:1] : beat_q[1:0];
    half      = narrow_q & beat_q[0];
    cur_word  = q_head.data[int'(word_idx)*WORD_W +: WORD_W];
  end

  always_comb begin
    ad_o      = '0;
    ad_oe     = 1'b0;
    cmd_o     = '0;
    vout      = 1'b0;
    release_o = 1'b0;
    case (state_q)
      S_ADDR: begin
        vout  = 1'b1;
        ad_oe = 1'b1;
        ad_o  = WORD_W'(q_head.addr);
        cmd_o = {1'b0, type_code(q_head.kind), 5'b0};
      end
      S_REL: release_o = 1'b1;
      S_WDAT: begin
        ad_oe = 1'b1;
        vout  = pace_eff[slot_q];
        if (!narrow_q)  ad_o = cur_word;
        else if (half)  ad_o = {{(WORD_W/2){1'b0}}, cur_word[WORD_W-1:WORD_W/2]};
        else            ad_o = {{(WORD_W/2){1'b0}}, cur_word[WORD_W/2-1:0]};
        if (vout) cmd_o = {1'b1, 2'b00, last_beat, 5'b0};
      end
      default: ;
    endcase
    cmdp_o = ^cmd_o;
  end

  assign cap      = (state_q == S_RDAT) && vin && cmd_i_data;
  assign cap_half = beat_q[0];
  assign cap_last = last_beat;
  assign narrow_o = narrow_q;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    slot_d  = slot_q;
    q_pop   = 1'b0;
    case (state_q)
      S_IDLE: if (issue_ok) state_d = S_ADDR;
      S_ADDR: begin
        beat_d  = '0;
        slot_d  = '0;
        state_d = rd_kind ? S_REL : S_WDAT;
      end
      S_REL: state_d = S_RDAT;
      S_RDAT: if (cap) begin
        if (last_beat) begin
          state_d = S_IDLE;
          q_pop   = 1'b1;
        end else begin
          beat_d = beat_q + 1'b1;
        end
      end
      S_WDAT: begin
        slot_d = slot_q + 1'b1;
        if (vout) begin
          if (last_beat) begin
            state_d = S_IDLE;
            q_pop   = 1'b1;
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      beat_q  <= '0;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      slot_q  <= slot_d;
    end
  end

  // R3: read address only after read-ready, write address only after write-ready
  p_rd_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vout && !cmd_o[8] && !cmd_o[6]) |-> $past(rd_rdy));
  p_wr_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vout && !cmd_o[8] && cmd_o[6]) |-> $past(wr_rdy));
  // R4: bus handed over right after a read address
  p_release_after_rdaddr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vout && !cmd_o[8] && !cmd_o[6]) |=> (release_o && !ad_oe));
  p_release_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({release_o, vout}));
  // R11: nothing driven in the cycle after a final write beat
  p_gap_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vout && cmd_o[8] && cmd_o[5]) |=> !vout);
endmodule

// File: rtl/sbr_rd_path.sv
module sbr_rd_path
  import sbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              cap_half,
  input  logic              cap_last,
  input  logic              narrow,
  input  logic [WORD_W-1:0] ad_i,
  input  logic [LANES-1:0]  chk_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              cmdp_i,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_last,
  output logic              par_err
);
  localparam int HALF_W = WORD_W / 2;

  logic [LANES-1:0]  calc_par, lane_mask;
  logic [HALF_W-1:0] lo_q;
  logic              lo_en, word_done, beat_bad;
  logic [WORD_W-1:0] word_d;

  sbr_parity_gen #(.NLANES(LANES)) i_chk (.data(ad_i), .par(calc_par));

  always_comb begin
    lane_mask = narrow ? {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}} : {LANES{1'b1}};
    beat_bad  = (|((calc_par ^ chk_i) & lane_mask)) || ((^cmd_i) != cmdp_i);
    lo_en     = cap && narrow && !cap_half;
    word_done = cap && (!narrow || cap_half);
    word_d    = narrow ? {ad_i[HALF_W-1:0], lo_q} : ad_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_last  <= 1'b0;
      par_err   <= 1'b0;
    end else begin
      if (lo_en) lo_q <= ad_i[HALF_W-1:0];
      rsp_valid <= word_done;
      if (word_done) begin
        rsp_data <= word_d;
        rsp_last <= cap_last;
      end
      if (cap && beat_bad) par_err <= 1'b1;
    end
  end

  p_rsp_follows_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cap));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(par_err));
endmodule

// File: rtl/sbr_requester.sv
module sbr_requester
  import sbr_pkg::*;
#(
  parameter int QDEPTH = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_narrow,
  input  logic [3:0]                  cfg_pace,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [1:0]                  req_kind,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [BLK_WORDS*WORD_W-1:0] req_wdata,
  output logic                        rsp_valid,
  output logic [WORD_W-1:0]           rsp_data,
  output logic                        rsp_last,
  output logic                        par_err,
  output logic [WORD_W-1:0]           bus_ad_o,
  input  logic [WORD_W-1:0]           bus_ad_i,
  output logic                        bus_ad_oe,
  output logic [LANES-1:0]            bus_chk_o,
  input  logic [LANES-1:0]            bus_chk_i,
  output logic [CMD_W-1:0]            bus_cmd_o,
  input  logic [CMD_W-1:0]            bus_cmd_i,
  output logic                        bus_cmdp_o,
  input  logic                        bus_cmdp_i,
  output logic                        bus_vout,
  input  logic                        bus_vin,
  input  logic                        bus_rd_rdy,
  input  logic                        bus_wr_rdy,
  output logic                        bus_release
);
  req_t in_req, head;
  logic push, head_valid, pop, cap, cap_half, cap_last, narrow;

  assign in_req = '{kind: kind_e'(req_kind), addr: req_addr, data: req_wdata};
  assign push   = req_valid && req_ready;

  sbr_req_queue #(.DEPTH(QDEPTH)) i_queue (
    .clk(clk), .rst_n(rst_n), .push(push), .push_req(in_req),
    .can_push(req_ready), .pop(pop), .head_valid(head_valid), .head(head)
  );

  sbr_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow), .cfg_pace(cfg_pace),
    .q_valid(head_valid), .q_head(head), .q_pop(pop),
    .rd_rdy(bus_rd_rdy), .wr_rdy(bus_wr_rdy), .vin(bus_vin),
    .cmd_i_data(bus_cmd_i[8]), .ad_o(bus_ad_o), .ad_oe(bus_ad_oe),
    .cmd_o(bus_cmd_o), .cmdp_o(bus_cmdp_o), .vout(bus_vout),
    .release_o(bus_release), .cap(cap), .cap_half(cap_half),
    .cap_last(cap_last), .narrow_o(narrow)
  );

  sbr_parity_gen #(.NLANES(LANES)) i_gen (.data(bus_ad_o), .par(bus_chk_o));

  sbr_rd_path i_rd (
    .clk(clk), .rst_n(rst_n), .cap(cap), .cap_half(cap_half),
    .cap_last(cap_last), .narrow(narrow), .ad_i(bus_ad_i), .chk_i(bus_chk_i),
    .cmd_i(bus_cmd_i), .cmdp_i(bus_cmdp_i), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_last(rsp_last), .par_err(par_err)
  );

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!bus_vout && !bus_release));
endmodule

// File: tb/test_sbr_requester.sv
module test_sbr_requester;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n, cfg_narrow, req_valid, req_ready, rsp_valid, rsp_last, par_err;
  logic [3:0]   cfg_pace;
  logic [1:0]   req_kind;
  logic [31:0]  req_addr;
  logic [255:0] req_wdata;
  logic [63:0]  rsp_data, bus_ad_o, bus_ad_i;
  logic         bus_ad_oe, bus_cmdp_o, bus_cmdp_i, bus_vout, bus_vin;
  logic         bus_rd_rdy, bus_wr_rdy, bus_release;
  logic [7:0]   bus_chk_o, bus_chk_i;
  logic [8:0]   bus_cmd_o, bus_cmd_i;

  sbr_requester i_sbr_requester (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct packed {
    bit narrow; bit [3:0] pace; bit [1:0] kind; bit [31:0] addr;
    bit [7:0] seed; bit perr; bit gap;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'h0, 2'b01, 32'h1000_0040, 8'h11, 1'b0, 1'b0},
    '{1'b0, 4'hF, 2'b11, 32'h2000_0100, 8'h22, 1'b0, 1'b0},
    '{1'b0, 4'h3, 2'b11, 32'h0000_3000, 8'h33, 1'b0, 1'b0},
    '{1'b1, 4'h5, 2'b01, 32'h4000_0008, 8'h44, 1'b0, 1'b0},
    '{1'b1, 4'h0, 2'b11, 32'h0000_5000, 8'h55, 1'b0, 1'b0},
    '{1'b0, 4'h0, 2'b00, 32'h6000_0010, 8'h66, 1'b0, 1'b1},
    '{1'b0, 4'h0, 2'b10, 32'h7000_0200, 8'h77, 1'b0, 1'b1},
    '{1'b1, 4'h0, 2'b10, 32'h0000_8000, 8'h88, 1'b1, 1'b0},
    '{1'b1, 4'h0, 2'b00, 32'h9000_0004, 8'h99, 1'b0, 1'b1},
    '{1'b0, 4'h0, 2'b10, 32'h0000_A000, 8'hAA, 1'b1, 1'b0}
  };

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] bpar(logic [63:0] d);
    logic [7:0] p;
    for (int k = 0; k < 8; k++) p[k] = ^d[k*8 +: 8];
    return p;
  endfunction

  function automatic logic [63:0] mkword(logic [31:0] a, logic [7:0] s, int w);
    return {s, 8'(w), 16'h5AC3, a ^ {4{s}}};
  endfunction

  function automatic logic [2:0] tcode(logic [1:0] k);
    case (k)
      2'b00: return 3'b000;
      2'b10: return 3'b001;
      2'b01: return 3'b010;
      default: return 3'b011;
    endcase
  endfunction

  function automatic int nbeats(bit narrow, logic [1:0] k);
    int w = k[1] ? 4 : 1;
    return narrow ? 2 * w : w;
  endfunction

  task automatic do_reset(bit narrow, logic [3:0] pace);
    @(negedge clk);
    rst_n = 1'b0; cfg_narrow = narrow; cfg_pace = pace;
    req_valid = 0; req_kind = 0; req_addr = 0; req_wdata = 0;
    bus_ad_i = 0; bus_chk_i = 0; bus_cmd_i = 0; bus_cmdp_i = 0; bus_vin = 0;
    bus_rd_rdy = 1; bus_wr_rdy = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(logic [1:0] kind, logic [31:0] addr, logic [7:0] seed);
    req_valid = 1; req_kind = kind; req_addr = addr;
    for (int w = 0; w < 4; w++) req_wdata[w*64 +: 64] = mkword(addr, seed, w);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic addr_cycle(logic [1:0] kind, logic [31:0] addr);
    int n = 0;
    while (!(bus_vout && !bus_cmd_o[8]) && n < 60) begin
      @(negedge clk); n++;
    end
    chk("R2", "address cycle seen", 64'(bus_vout && !bus_cmd_o[8]), 64'd1);
    chk("R2", "address value", bus_ad_o, {32'h0, addr});
    chk("R2", "address cmd", 64'(bus_cmd_o), 64'({1'b0, tcode(kind), 5'b0}));
    chk("R2", "cmd parity", 64'(bus_cmdp_o), 64'(^bus_cmd_o));
    chk("R2", "drive enable", 64'(bus_ad_oe), 64'd1);
    chk("R5", "address check bits", 64'(bus_chk_o), 64'(bpar(bus_ad_o)));
  endtask

  task automatic run_write(bit narrow, logic [3:0] pace, logic [1:0] kind,
                           logic [31:0] addr, logic [7:0] seed);
    logic [3:0] pm = (pace == 0) ? 4'hF : pace;
    int nb = nbeats(narrow, kind);
    int b = 0, s = 0, guard = 0;
    logic [63:0] w, e;
    addr_cycle(kind, addr);
    while (b < nb && guard < 40) begin
      @(negedge clk); guard++;
      chk("R6", "pacing slot", 64'(bus_vout), 64'(pm[s]));
      if (bus_vout) begin
        w = mkword(addr, seed, narrow ? b / 2 : b);
        e = !narrow ? w : ((b % 2) ? {32'h0, w[63:32]} : {32'h0, w[31:0]});
        chk(narrow ? "R7" : "R5", "write data", bus_ad_o, e);
        chk("R5", "data cmd", 64'(bus_cmd_o), 64'({1'b1, 2'b0, b == nb - 1, 5'b0}));
        chk("R5", "data check bits", 64'(bus_chk_o), 64'(bpar(e)));
        chk("R2", "data cmd parity", 64'(bus_cmdp_o), 64'(^bus_cmd_o));
        b++;
      end
      s = (s + 1) % 4;
    end
    @(negedge clk);
    chk("R11", "idle after final write beat", 64'(bus_vout), 64'd0);
  endtask

  task automatic chk_pend(bit pv, logic [63:0] pd, bit pl);
    chk("R8", "rsp_valid", 64'(rsp_valid), 64'(pv));
    if (pv) begin
      chk("R8", "rsp_data", rsp_data, pd);
      chk("R8", "rsp_last", 64'(rsp_last), 64'(pl));
    end
  endtask

  task automatic run_read(bit narrow, logic [1:0] kind, logic [31:0] addr,
                          logic [7:0] seed, bit perr, bit gap);
    int nb = nbeats(narrow, kind);
    bit pv = 0, pl = 0;
    logic [63:0] pd = 0, w;
    logic [31:0] h;
    addr_cycle(kind, addr);
    @(negedge clk);
    chk("R4", "release after read address", 64'(bus_release), 64'd1);
    chk("R4", "bus released", 64'(bus_ad_oe), 64'd0);
    @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      if (gap && b == 1) begin
        chk_pend(pv, pd, pl); pv = 0;
        bus_vin = 1; bus_cmd_i = 9'h000; bus_cmdp_i = 0;
        bus_ad_i = 64'hDEAD_BEEF_0BAD_F00D; bus_chk_i = bpar(bus_ad_i);
        @(negedge clk);
      end
      chk_pend(pv, pd, pl);
      chk("R4", "no drive during read", 64'(bus_ad_oe), 64'd0);
      w = mkword(addr, seed, narrow ? b / 2 : b);
      if (narrow) begin
        h = (b % 2) ? w[63:32] : w[31:0];
        bus_ad_i  = {32'hFFFF_0000, h};
        bus_chk_i = {4'hA, bpar({32'h0, h})[3:0]};
      end else begin
        bus_ad_i  = w;
        bus_chk_i = bpar(w);
      end
      if (perr && b == 0) bus_chk_i[0] = ~bus_chk_i[0];
      bus_cmd_i  = {1'b1, 2'b0, b == nb - 1, 5'b0};
      bus_cmdp_i = ^bus_cmd_i;
      bus_vin    = 1;
      pv = !narrow || (b % 2 == 1); pd = w; pl = (b == nb - 1);
      @(negedge clk);
    end
    bus_vin = 0; bus_cmd_i = 0; bus_cmdp_i = 0;
    chk_pend(pv, pd, pl);
    chk("R9", "parity flag after read", 64'(par_err), 64'(perr));
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    report();
  end

  initial begin
    rst_n = 0; cfg_narrow = 0; cfg_pace = 0; req_valid = 0; req_kind = 0;
    req_addr = 0; req_wdata = 0; bus_ad_i = 0; bus_chk_i = 0; bus_cmd_i = 0;
    bus_cmdp_i = 0; bus_vin = 0; bus_rd_rdy = 1; bus_wr_rdy = 1;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1", "vout in reset", 64'(bus_vout), 64'd0);
    chk("R1", "release in reset", 64'(bus_release), 64'd0);
    chk("R1", "oe in reset", 64'(bus_ad_oe), 64'd0);
    chk("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk("R1", "par_err in reset", 64'(par_err), 64'd0);
    do_reset(0, 0);
    chk("R1", "req_ready after reset", 64'(req_ready), 64'd1);
    chk("R1", "vout after reset", 64'(bus_vout), 64'd0);

    for (int i = 0; i < NV; i++) begin
      do_reset(VECS[i].narrow, VECS[i].pace);
      push(VECS[i].kind, VECS[i].addr, VECS[i].seed);
      if (VECS[i].kind[0])
        run_write(VECS[i].narrow, VECS[i].pace, VECS[i].kind, VECS[i].addr, VECS[i].seed);
      else
        run_read(VECS[i].narrow, VECS[i].kind, VECS[i].addr, VECS[i].seed,
                 VECS[i].perr, VECS[i].gap);
    end

    // R3: read held off by read-ready
    do_reset(0, 0);
    bus_rd_rdy = 0;
    push(2'b00, 32'h0000_0C00, 8'h5C);
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      chk("R3", "no read address without ready", 64'(bus_vout), 64'd0);
    end
    bus_rd_rdy = 1;
    run_read(0, 2'b00, 32'h0000_0C00, 8'h5C, 0, 0);

    // R3: write held off by write-ready
    bus_wr_rdy = 0;
    push(2'b11, 32'h0000_0D00, 8'h5D);
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      chk("R3", "no write address without ready", 64'(bus_vout), 64'd0);
    end
    bus_wr_rdy = 1;
    run_write(0, 0, 2'b11, 32'h0000_0D00, 8'h5D);

    // R10: queue fills, then drains in order
    do_reset(1, 0);
    bus_rd_rdy = 0;
    push(2'b00, 32'h0000_0E10, 8'h61);
    push(2'b10, 32'h0000_0E20, 8'h62);
    chk("R10", "ready low when full", 64'(req_ready), 64'd0);
    bus_rd_rdy = 1;
    run_read(1, 2'b00, 32'h0000_0E10, 8'h61, 0, 0);
    chk("R10", "ready back after drain", 64'(req_ready), 64'd1);
    run_read(1, 2'b10, 32'h0000_0E20, 8'h62, 0, 0);

    // R11: two queued writes, second waits for first to finish
    do_reset(0, 4'h9);
    bus_wr_rdy = 0;
    push(2'b01, 32'h0000_0F10, 8'h71);
    push(2'b11, 32'h0000_0F20, 8'h72);
    bus_wr_rdy = 1;
    run_write(0, 4'h9, 2'b01, 32'h0000_0F10, 8'h71);
    run_write(0, 4'h9, 2'b11, 32'h0000_0F20, 8'h72);

    // R9: error is sticky across a clean read, cleared by reset
    do_reset(0, 0);
    push(2'b00, 32'h0000_1110, 8'h81);
    run_read(0, 2'b00, 32'h0000_1110, 8'h81, 1, 0);
    push(2'b00, 32'h0000_1120, 8'h82);
    addr_cycle(2'b00, 32'h0000_1120);
    repeat (2) @(negedge clk);
    bus_ad_i = 64'h1; bus_chk_i = 8'h1; bus_cmd_i = 9'h120; bus_cmdp_i = 0;
    bus_vin = 1;
    @(negedge clk);
    bus_vin = 0; bus_cmd_i = 0;
    chk("R9", "sticky after clean beat", 64'(par_err), 64'd1);
    do_reset(0, 0);
    chk("R9", "cleared by reset", 64'(par_err), 64'd0);

    // R9: command parity mismatch alone flags an error
    push(2'b00, 32'h0000_1130, 8'h83);
    addr_cycle(2'b00, 32'h0000_1130);
    repeat (2) @(negedge clk);
    bus_ad_i = 64'h3; bus_chk_i = bpar(64'h3); bus_cmd_i = 9'h120; bus_cmdp_i = 1;
    bus_vin = 1;
    @(negedge clk);
    bus_vin = 0; bus_cmd_i = 0; bus_cmdp_i = 0;
    chk("R9", "command parity error", 64'(par_err), 64'd1);
    chk("R8", "word delivered despite error", rsp_data, 64'h3);

    repeat (3) @(negedge clk);
    report();
  end
endmodule